// File: doc/BRIEF.md
# Calibration Pulse Generator with Reverse-Power Flag

This block turns a stream of signed real-power samples into a fast calibration pulse train and a power-direction flag. Each accepted sample is added to a short signed accumulator. When the accumulator's magnitude reaches a step size, the block emits one active-high pulse and moves the accumulator one step back toward zero. The step size is a fixed division of the slow-output energy quantum `2^BASE_LOG2`, so the pulse rate is a chosen multiple of the slow outputs' rate. A 3-bit rate mode picks both that multiple and the rule that sets the pulse width.

Pulses are normally `WIDE_CYC` clocks long. When the time between pulse starts falls below twice that length, each pulse lasts half of the period just measured. One mode uses the highest multiple with a fixed, very short width. Negative power produces pulses in the same way, from its magnitude. The direction flag takes the accumulator's sign only at the instant a pulse is issued, so it follows the power direction without being latched. Samples whose magnitude is under a no-load limit are dropped so the output does not creep.

Top module: `cf_pulse_gen`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `cal_pulse` and `rev_flag` are 0.
- R2: `rate_mode` is the bit triple {fast select, high select, low select}. The step size is `2^(BASE_LOG2-k)`, where k is 7 for 100, 6 for 000 and 101, 5 for 001 and 110, 4 for 010 and 111, and 11 for 011.
- R3: When the block is idle and the accumulator is at or above +step, or at or below -step, a pulse is issued. The accumulator moves one step toward zero on that edge, and `cal_pulse` rises on the following clock.
- R4: If a pulse starts `2*WIDE_CYC` or more clocks after the previous one (or is the first since reset or since a mode change), it lasts `WIDE_CYC` clocks.
- R5: If a pulse starts P clocks after the previous one, with P below `2*WIDE_CYC`, it lasts floor(P/2) clocks.
- R6: In mode 011 every pulse lasts `SHORT_CYC` clocks.
- R7: When a pulse is issued, `rev_flag` takes 1 if the accumulator was negative and 0 otherwise. It changes at no other time.
- R8: A sample whose magnitude is below `CREEP_MIN` is not accumulated. A long run of such samples yields no pulse.
- R9: A change of `rate_mode` clears the accumulator, drops the sample of that cycle and resets the period measurement. A pulse already in progress runs to its full length.
- R10: No pulse is issued while `cal_pulse` is high, so at least one low clock separates pulses. Energy that arrives in the meantime stays in the accumulator, which saturates at ±(2^(ACC_W-1)-1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | A power sample is present this cycle |
| smp_power | input | SAMPLE_W | Signed real-power sample |
| rate_mode | input | 3 | Rate and width-rule select {fast, high, low} |
| cal_pulse | output | 1 | Active-high calibration pulse |
| rev_flag | output | 1 | 1 when the last issued pulse came from negative power |

## Verification
The bench uses the default parameters: a 2^14 energy quantum, an 18-bit accumulator, `WIDE_CYC`=40 and `SHORT_CYC`=3. With these values the smallest step is only 8 counts, so saturation is reached within a few hundred cycles of full-scale input. The 80-clock boundary between the halved and the full width can be crossed in both directions with short streams of constant samples. Every one of the eight modes is driven with random streams of both polarities. Random mode changes are mixed in so that clearing during a pulse is exercised as well.

// File: rtl/cf_pkg.sv
package cf_pkg;

   typedef logic [2:0] cf_mode_t;

   localparam int MAX_MULT_LOG2 = 11;
   localparam cf_mode_t NARROW_MODE = 3'b011;

   // log2 of the pulse-rate multiple over the slow outputs
   function automatic int mult_log2(input cf_mode_t m);
      case (m)
         3'b100:          return 7;
         3'b000, 3'b101:  return 6;
         3'b001, 3'b110:  return 5;
         3'b010, 3'b111:  return 4;
         default:         return MAX_MULT_LOG2;
      endcase
   endfunction

   function automatic logic is_narrow(input cf_mode_t m);
      return m == NARROW_MODE;
   endfunction

endpackage

// File: rtl/cf_rate_decode.sv
module cf_rate_decode
   import cf_pkg::*;
#(
   parameter int BASE_LOG2 = 14,
   parameter int ACC_W     = 18
) (
   input  cf_mode_t           mode,
   output logic [ACC_W-1:0]   step,
   output logic               narrow
);
   logic [ACC_W-1:0] step_tbl [8];

   if (BASE_LOG2 - MAX_MULT_LOG2 < 1) begin : g_chk_base
      $error("BASE_LOG2 too small for the fastest rate");
   end
   if (BASE_LOG2 > ACC_W - 3) begin : g_chk_acc
      $error("ACC_W must leave headroom above the largest step");
   end

   for (genvar i = 0; i < 8; i++) begin : g_tbl
      assign step_tbl[i] = ACC_W'(1) << (BASE_LOG2 - mult_log2(cf_mode_t'(i)));
   end

   assign step   = step_tbl[mode];
   assign narrow = is_narrow(mode);
endmodule

// File: rtl/cf_energy_accum.sv
module cf_energy_accum #(
   parameter int SAMPLE_W  = 12,
   parameter int ACC_W     = 18,
   parameter int CREEP_MIN = 4,
   parameter bit SATURATE  = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       clear,
   input  logic                       idle,
   input  logic                       valid,
   input  logic signed [SAMPLE_W-1:0] sample,
   input  logic [ACC_W-1:0]           step,
   output logic                       fire,
   output logic                       neg,
   output logic signed [ACC_W-1:0]    acc
);
   localparam int EXT_W = ACC_W + 2;
   localparam logic signed [EXT_W-1:0] MAX_X = EXT_W'((64'sd1 <<< (ACC_W - 1)) - 64'sd1);
   localparam logic signed [EXT_W-1:0] MIN_X = -MAX_X;
   localparam logic signed [EXT_W-1:0] ZERO_X = '0;

   if (SAMPLE_W >= ACC_W) begin : g_chk_w
      $error("SAMPLE_W must be narrower than ACC_W");
   end
   if (CREEP_MIN < 0) begin : g_chk_creep
      $error("CREEP_MIN must not be negative");
   end

   logic signed [ACC_W-1:0] acc_q;
   logic signed [EXT_W-1:0] acc_x, step_x, samp_x, samp_mag, add_x, sub_x, sum_x;
   logic signed [ACC_W-1:0] acc_nxt;
   logic                    keep;

   assign acc_x    = {{2{acc_q[ACC_W-1]}}, acc_q};
   assign step_x   = {2'b00, step};
   assign samp_x   = {{(EXT_W-SAMPLE_W){sample[SAMPLE_W-1]}}, sample};
   assign samp_mag = samp_x[EXT_W-1] ? -samp_x : samp_x;
   assign keep     = valid && (samp_mag >= EXT_W'(CREEP_MIN));

   assign neg  = acc_q[ACC_W-1];
   assign fire = !clear && idle && ((acc_x >= step_x) || (acc_x <= -step_x));

   assign add_x = keep ? samp_x : ZERO_X;
   assign sub_x = !fire ? ZERO_X : (neg ? -step_x : step_x);
   assign sum_x = acc_x + add_x - sub_x;

   if (SATURATE) begin : g_sat
      always_comb begin
         if (sum_x > MAX_X)      acc_nxt = MAX_X[ACC_W-1:0];
         else if (sum_x < MIN_X) acc_nxt = MIN_X[ACC_W-1:0];
         else                    acc_nxt = sum_x[ACC_W-1:0];
      end
   end else begin : g_wrap
      assign acc_nxt = sum_x[ACC_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     acc_q <= '0;
      else if (clear) acc_q <= '0;
      else            acc_q <= acc_nxt;
   end

   assign acc = acc_q;
endmodule

// File: rtl/cf_pulse_shaper.sv
module cf_pulse_shaper #(
   parameter int WIDE_CYC  = 40,
   parameter int SHORT_CYC = 3,
   parameter int WCNT_W    = $clog2(((WIDE_CYC > SHORT_CYC) ? WIDE_CYC : SHORT_CYC) + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              fire,
   input  logic              neg,
   input  logic              narrow,
   output logic              cf,
   output logic              revp,
   output logic [WCNT_W-1:0] wcnt
);
   localparam int GAP_SAT = 2 * WIDE_CYC;
   localparam int GAP_W   = $clog2(GAP_SAT + 2);

   if (WIDE_CYC < 1 || SHORT_CYC < 1) begin : g_chk_len
      $error("pulse lengths must be at least one clock");
   end

   logic [GAP_W-1:0]  gap_q;
   logic [GAP_W:0]    period;
   logic [GAP_W:0]    half;
   logic [WCNT_W-1:0] w_q, w_sel;
   logic              revp_q;

   assign period = {1'b0, gap_q} + 1'b1;
   assign half   = period >> 1;

   always_comb begin
      if (narrow)                            w_sel = WCNT_W'(SHORT_CYC);
      else if (period >= (GAP_W+1)'(GAP_SAT)) w_sel = WCNT_W'(WIDE_CYC);
      else                                   w_sel = WCNT_W'(half);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gap_q  <= GAP_W'(GAP_SAT);
         w_q    <= '0;
         revp_q <= 1'b0;
      end else if (fire) begin
         gap_q  <= '0;
         w_q    <= w_sel;
         revp_q <= neg;
      end else begin
         if (w_q != '0) w_q <= w_q - 1'b1;
         if (clear)                          gap_q <= GAP_W'(GAP_SAT);
         else if (gap_q != GAP_W'(GAP_SAT))  gap_q <= gap_q + 1'b1;
      end
   end

   assign cf   = (w_q != '0);
   assign revp = revp_q;
   assign wcnt = w_q;
endmodule

// File: rtl/cf_pulse_gen.sv
module cf_pulse_gen
   import cf_pkg::*;
#(
   parameter int SAMPLE_W  = 12,
   parameter int BASE_LOG2 = 14,
   parameter int ACC_W     = 18,
   parameter int CREEP_MIN = 4,
   parameter int WIDE_CYC  = 40,
   parameter int SHORT_CYC = 3,
   parameter bit SATURATE  = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       smp_valid,
   input  logic signed [SAMPLE_W-1:0] smp_power,
   input  logic [2:0]                 rate_mode,
   output logic                       cal_pulse,
   output logic                       rev_flag
);
   localparam int WCNT_W = $clog2(((WIDE_CYC > SHORT_CYC) ? WIDE_CYC : SHORT_CYC) + 1);

   cf_mode_t                mode_q;
   logic                    changed;
   logic [ACC_W-1:0]        step;
   logic                    narrow, fire, neg;
   logic signed [ACC_W-1:0] acc;
   logic [WCNT_W-1:0]       wcnt;

   always_ff @(posedge clk) begin
      if (!rst_n) mode_q <= '0;
      else        mode_q <= rate_mode;
   end
   assign changed = (rate_mode != mode_q);

   cf_rate_decode #(.BASE_LOG2(BASE_LOG2), .ACC_W(ACC_W)) u_dec (
      .mode   (rate_mode),
      .step   (step),
      .narrow (narrow)
   );

   cf_energy_accum #(
      .SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W), .CREEP_MIN(CREEP_MIN), .SATURATE(SATURATE)
   ) u_acc (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (changed),
      .idle   (!cal_pulse),
      .valid  (smp_valid),
      .sample (smp_power),
      .step   (step),
      .fire   (fire),
      .neg    (neg),
      .acc    (acc)
   );

   cf_pulse_shaper #(.WIDE_CYC(WIDE_CYC), .SHORT_CYC(SHORT_CYC), .WCNT_W(WCNT_W)) u_shp (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (changed),
      .fire   (fire),
      .neg    (neg),
      .narrow (narrow),
      .cf     (cal_pulse),
      .revp   (rev_flag),
      .wcnt   (wcnt)
   );
endmodule

// File: rtl/cf_pulse_chk.sv
module cf_pulse_chk #(
   parameter int ACC_W     = 18,
   parameter int WCNT_W    = 6,
   parameter int SHORT_CYC = 3
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    cf,
   input logic                    revp,
   input logic                    fire,
   input logic                    narrow,
   input logic                    changed,
   input logic [WCNT_W-1:0]       wcnt,
   input logic signed [ACC_W-1:0] acc
);
   p_reset_quiet_r1: assert property (@(posedge clk)
      !rst_n |=> (!cf && !revp));

   p_pulse_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> cf);

   p_narrow_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && narrow) |=> (wcnt == WCNT_W'(SHORT_CYC)));

   p_flag_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !fire |=> $stable(revp));

   p_clear_on_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
      changed |=> (acc == '0));

   p_no_overlap_r10: assert property (@(posedge clk) disable iff (!rst_n)
      fire |-> !cf);
endmodule

bind cf_pulse_gen cf_pulse_chk #(
   .ACC_W(ACC_W), .WCNT_W(WCNT_W), .SHORT_CYC(SHORT_CYC)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .cf      (cal_pulse),
   .revp    (rev_flag),
   .fire    (fire),
   .narrow  (narrow),
   .changed (changed),
   .wcnt    (wcnt),
   .acc     (acc)
);

// File: tb/sim_cf_pulse_gen.sv
module sim_cf_pulse_gen;
   localparam int SAMPLE_W  = 12;
   localparam int BASE_LOG2 = 14;
   localparam int ACC_W     = 18;
   localparam int CREEP_MIN = 4;
   localparam int WIDE_CYC  = 40;
   localparam int SHORT_CYC = 3;
   localparam int GAP_SAT   = 2 * WIDE_CYC;
   localparam int ACC_MAX   = (1 << (ACC_W - 1)) - 1;

   logic                       clk = 1'b0;
   logic                       rst_n = 1'b0;
   logic                       smp_valid = 1'b0;
   logic signed [SAMPLE_W-1:0] smp_power = '0;
   logic [2:0]                 rate_mode = 3'b000;
   logic                       cal_pulse, rev_flag;

   int checks = 0, fails = 0;
   int m_acc, m_gap, m_w, m_revp;
   logic [2:0] m_modeq;
   bit cf_prev = 1'b0;
   int run = 0, last_run = 0, rises = 0;

   always #10 clk = ~clk;

   cf_pulse_gen u0 (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_power(smp_power),
      .rate_mode(rate_mode), .cal_pulse(cal_pulse), .rev_flag(rev_flag)
   );

   // R2: step per mode
   function automatic int thr(input logic [2:0] m);
      int k;
      case (m)
         3'b100: k = 7;
         3'b000, 3'b101: k = 6;
         3'b001, 3'b110: k = 5;
         3'b010, 3'b111: k = 4;
         default: k = 11;
      endcase
      return 1 << (BASE_LOG2 - k);
   endfunction

   // R4 / R5 / R6: width rule
   function automatic int width_for(input logic [2:0] m, input int p);
      if (m == 3'b011) return SHORT_CYC;
      if (p >= GAP_SAT) return WIDE_CYC;
      return p / 2;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_acc = 0; m_gap = GAP_SAT; m_w = 0; m_revp = 0; m_modeq = 3'b000;
      end else begin
         int t, mag, seff, nxt;
         bit chg, ev;
         t    = thr(rate_mode);
         chg  = (rate_mode != m_modeq);
         ev   = !chg && (m_w == 0) && (m_acc >= t || m_acc <= -t);
         mag  = (smp_power < 0) ? -int'(smp_power) : int'(smp_power);
         seff = (smp_valid && mag >= CREEP_MIN) ? int'(smp_power) : 0;
         if (chg) nxt = 0;
         else begin
            nxt = m_acc + seff - (ev ? ((m_acc < 0) ? -t : t) : 0);
            if (nxt > ACC_MAX) nxt = ACC_MAX;
            if (nxt < -ACC_MAX) nxt = -ACC_MAX;
         end
         if (ev) begin
            m_w = width_for(rate_mode, m_gap + 1);
            m_revp = (m_acc < 0) ? 1 : 0;
            m_gap = 0;
         end else begin
            if (m_w > 0) m_w = m_w - 1;
            if (chg) m_gap = GAP_SAT;
            else if (m_gap < GAP_SAT) m_gap = m_gap + 1;
         end
         m_acc = nxt;
         m_modeq = rate_mode;
      end
   end

   task automatic tick(input string tag);
      @(negedge clk);
      checks++;
      if (cal_pulse !== (m_w != 0) || rev_flag !== m_revp[0]) begin
         fails++;
         $display("FAIL %s: cf=%0b revp=%0b expected cf=%0b revp=%0b",
                  tag, cal_pulse, rev_flag, (m_w != 0), m_revp[0]);
      end
      if (cal_pulse && !cf_prev) rises++;
      if (cal_pulse) run++;
      else if (cf_prev) begin last_run = run; run = 0; end
      cf_prev = cal_pulse;
   endtask

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic put(input bit v, input int s);
      smp_valid = v;
      smp_power = SAMPLE_W'(s);
   endtask

   initial begin
      #(20 * 190000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      rate_mode = 3'b100;
      repeat (3) tick("R1");
      check(cal_pulse == 1'b0, "R1 cf in reset", int'(cal_pulse), 0);
      check(rev_flag == 1'b0, "R1 flag in reset", int'(rev_flag), 0);
      rst_n = 1'b1;
      tick("R1");
      check(cal_pulse == 1'b0 && rev_flag == 1'b0, "R1 after reset", int'(cal_pulse), 0);

      // R8: sub-threshold samples never build up a pulse
      rises = 0;
      for (int i = 0; i < 500; i++) begin
         put(1'b1, $urandom_range(0, 6) - 3);
         tick("R8");
      end
      put(1'b0, 0);
      repeat (5) tick("R8");
      check(rises == 0, "R8 creep pulses", rises, 0);

      // R9: mode change discards stored energy
      rises = 0;
      put(1'b1, 127); tick("R9");
      put(1'b0, 0); rate_mode = 3'b000; tick("R9");
      rate_mode = 3'b100; tick("R9");
      put(1'b1, 1); tick("R9");
      put(1'b0, 0);
      repeat (60) tick("R9");
      check(rises == 0, "R9 cleared accumulator", rises, 0);

      // R3 / R4: single crossing, full-width pulse
      rises = 0;
      put(1'b1, 128); tick("R3");
      check(cal_pulse == 1'b0, "R3 no pulse in detect cycle", int'(cal_pulse), 0);
      put(1'b0, 0); tick("R3");
      check(cal_pulse == 1'b1, "R3 pulse next cycle", int'(cal_pulse), 1);
      repeat (100) tick("R4");
      check(rises == 1, "R4 pulse count", rises, 1);
      check(last_run == WIDE_CYC, "R4 wide width", last_run, WIDE_CYC);
      check(rev_flag == 1'b0, "R7 positive flag", int'(rev_flag), 0);

      // R7: direction flag follows sign only at issue
      put(1'b1, -130); tick("R7");
      put(1'b0, 0);
      repeat (100) tick("R7");
      check(rev_flag == 1'b1, "R7 negative flag", int'(rev_flag), 1);
      put(1'b1, 200); tick("R7");
      check(rev_flag == 1'b1, "R7 flag held before issue", int'(rev_flag), 1);
      put(1'b0, 0); tick("R7");
      check(rev_flag == 1'b0, "R7 flag at issue", int'(rev_flag), 0);
      repeat (60) tick("R7");

      // R6: fixed narrow pulses in mode 011
      rate_mode = 3'b011;
      for (int i = 0; i < 60; i++) begin put(1'b1, 8); tick("R6"); end
      put(1'b0, 0);
      repeat (20) tick("R6");
      check(last_run == SHORT_CYC, "R6 narrow width", last_run, SHORT_CYC);

      // R5: steady rate shorter than the wide limit halves the period
      rate_mode = 3'b100;
      for (int i = 0; i < 200; i++) begin put(1'b1, 16); tick("R5"); end
      check(last_run == 4, "R5 half-period width", last_run, 4);

      // R10: overload, accumulator clamps and pulses never merge
      rate_mode = 3'b011;
      for (int i = 0; i < 300; i++) begin put(1'b1, 2047); tick("R10"); end
      check(last_run == SHORT_CYC, "R10 separate pulses", last_run, SHORT_CYC);
      put(1'b0, 0);
      rate_mode = 3'b000; tick("R10");

      // R2 / R9: random streams over every mode
      for (int md = 0; md < 8; md++) begin
         rate_mode = 3'(md);
         for (int i = 0; i < 2500; i++) begin
            int s;
            s = int'($urandom_range(0, 300));
            if (((i / 500) % 2) == 1) s = -s;
            put($urandom_range(0, 3) != 0, s);
            if ($urandom_range(0, 399) == 0) begin
               rate_mode = 3'($urandom_range(0, 7));
               tick("R9");
            end else tick("R2");
         end
      end

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule